// File: doc/BRIEF.md
# Transmit Descriptor Ring Run Controller

This block governs the run state of a transmit DMA engine that walks a ring of fixed-stride descriptors in memory. Software raises a level-sensitive run bit to start the engine; the engine asks for the descriptor at its current ring position and inspects only its ownership flag. An owned descriptor lets a frame proceed. A descriptor still held by software parks the engine in a suspended state and raises a sticky "no buffer" flag. A poll strobe makes the engine try the same descriptor again.

Dropping the run bit halts the engine. If a frame is in flight, the halt waits for that frame to finish. The ring position survives a halt, so a later start resumes where the engine left off. After reset, the first start begins at the ring base. Each completed frame moves the position one stride forward, and the position wraps to the base after the last programmed entry. The memory bus protocol, descriptor parsing and data movement belong to neighbouring blocks.

Top module: `txdma_run_ctrl`

## Requirements
- R1: After reset, run_state is 00 (stopped), fetch_req is 0, buf_unavail is 0, and desc_addr equals ring_base.
- R2: In stopped, with run_en high at a clock edge, the next cycle shows run_state 01 (running) and fetch_req 1. desc_addr then holds the current ring position.
- R3: While fetch_req is high with run_en high, a desc_ack with desc_owned 1 ends the fetch, so that fetch_req drops and run_state stays 01. A desc_ack with desc_owned 0 moves the engine to run_state 10 (suspended) and sets buf_unavail in the next cycle.
- R4: Lowering run_en during a frame in progress keeps run_state at 01 until frame_done, and the engine stops at that edge. Lowering run_en while suspended or while fetching stops the engine at the next edge.
- R5: frame_done during a frame moves desc_addr from ring_base + i*STRIDE to ring_base + (i+1)*STRIDE. After entry ring_count-1 the address returns to ring_base. With run_en still high, the engine fetches the new position at once.
- R6: The ring position is kept across a stop, and a restart fetches the saved position rather than ring_base.
- R7: In suspended, poll_kick with run_en high returns to running with fetch_req 1 for the same desc_addr. poll_kick has no effect in any other state.
- R8: buf_unavail stays set until an unavail_clr pulse clears it. A new unowned descriptor in the same cycle as the clear keeps it set.
- R9: In stopped, desc_ack and frame_done have no effect on state, address or flag. desc_ack has no effect while a frame is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | Level run bit: high requests running, low requests stop |
| ring_base | input | ADDR_W | Byte address of ring entry 0 |
| ring_count | input | IDX_W | Number of ring entries (0 is treated as 1) |
| desc_ack | input | 1 | Descriptor fetch response valid |
| desc_owned | input | 1 | Ownership flag of the returned descriptor (1 = engine owns it) |
| frame_done | input | 1 | Transmit path finished the current frame |
| poll_kick | input | 1 | Retry strobe for a suspended engine |
| unavail_clr | input | 1 | Write-one-to-clear pulse for buf_unavail |
| desc_addr | output | ADDR_W | Address of the current descriptor |
| fetch_req | output | 1 | Level request to fetch the descriptor at desc_addr |
| run_state | output | 2 | 00 stopped, 01 running, 10 suspended |
| buf_unavail | output | 1 | Sticky flag: an unowned descriptor was met |

## Verification
The properties assume that ring_base and ring_count are held constant while the engine runs. They also assume that frame_done and desc_ack come only in answer to the engine's own phases. Without those assumptions, the address-advance and position-hold properties would compare against a moving base. The stimulus programs the ring once before reset is released and never changes it. It also injects out-of-phase acknowledgements and frame completions only in the states where R9 says they must be ignored. Those injections check the ignore paths without breaking the assumed handshake.

// File: rtl/txdma_pkg.sv
// Shared types for the transmit descriptor ring run controller.
// Assumes: nothing beyond the encodings declared here.
package txdma_pkg;

    // Internal phase; running is split into fetch and frame-in-progress.
    typedef enum logic [1:0] {
        PH_STOP  = 2'd0,
        PH_FETCH = 2'd1,
        PH_SUSP  = 2'd2,
        PH_XFER  = 2'd3
    } phase_t;

    // Externally visible run state encoding.
    localparam logic [1:0] RS_STOPPED   = 2'b00;
    localparam logic [1:0] RS_RUNNING   = 2'b01;
    localparam logic [1:0] RS_SUSPENDED = 2'b10;

endpackage

// File: rtl/txdma_ring_pos.sv
// Ring position register: holds the current descriptor index and
// produces its byte address. Advances one entry on request and wraps
// after the last programmed entry.
// Assumes: STRIDE is a power of two; ring_count of 0 behaves like 1.
module txdma_ring_pos #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  ring_count,
    output logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] addr
);
    localparam int STRIDE_SH = $clog2(STRIDE);

    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] next_idx;

    // Compute the last valid index and the wrapped successor.
    always_comb begin
        last_idx = (ring_count == '0) ? '0 : ring_count - 1'b1;
        next_idx = (idx >= last_idx) ? '0 : idx + 1'b1;
    end

    // Hold the index; move forward one entry when told to.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (advance) idx <= next_idx;
    end

    // Byte address of the current entry.
    assign addr = ring_base + (ADDR_W'(idx) << STRIDE_SH);

endmodule

// File: rtl/txdma_run_fsm.sv
// Run-state sequencer: stopped, fetching, frame in progress, suspended.
// Starts only from stopped, defers a stop until the current frame ends,
// suspends on an unowned descriptor and retries on a poll strobe.
// Assumes: desc_ack is meaningful only while fetch_req is high.
module txdma_run_fsm
    import txdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       desc_ack,
    input  logic       desc_owned,
    input  logic       frame_done,
    input  logic       poll_kick,
    output logic       advance,
    output logic       unowned_hit,
    output logic       fetch_req,
    output logic [1:0] run_state
);
    phase_t phase, phase_nx;

    // Next-phase selection and event pulses.
    always_comb begin
        phase_nx    = phase;
        advance     = 1'b0;
        unowned_hit = 1'b0;
        unique case (phase)
            PH_STOP:  if (run_en) phase_nx = PH_FETCH;
            PH_FETCH: begin
                if (!run_en)        phase_nx = PH_STOP;
                else if (desc_ack) begin
                    if (desc_owned) phase_nx = PH_XFER;
                    else begin
                        phase_nx    = PH_SUSP;
                        unowned_hit = 1'b1;
                    end
                end
            end
            PH_XFER: if (frame_done) begin
                advance  = 1'b1;
                phase_nx = run_en ? PH_FETCH : PH_STOP;
            end
            PH_SUSP: begin
                if (!run_en)        phase_nx = PH_STOP;
                else if (poll_kick) phase_nx = PH_FETCH;
            end
            default: phase_nx = PH_STOP;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_STOP;
        else        phase <= phase_nx;
    end

    // Map the internal phase onto the visible run state.
    always_comb begin
        fetch_req = (phase == PH_FETCH);
        unique case (phase)
            PH_FETCH, PH_XFER: run_state = RS_RUNNING;
            PH_SUSP:           run_state = RS_SUSPENDED;
            default:           run_state = RS_STOPPED;
        endcase
    end

endmodule

// File: rtl/txdma_sticky_flag.sv
// Sticky status bit with write-one-to-clear; a set wins over a clear
// that arrives in the same cycle.
// Assumes: set and clr are single-cycle qualified pulses.
module txdma_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Hold, set or clear the flag.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/txdma_run_ctrl.sv
// Top of the transmit descriptor ring run controller: joins the run
// sequencer, the ring position register and the no-buffer flag.
// Assumes: ring_base and ring_count are static while the engine runs.
module txdma_run_ctrl #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8,
    parameter int STRIDE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W-1:0]  ring_count,
    input  logic              desc_ack,
    input  logic              desc_owned,
    input  logic              frame_done,
    input  logic              poll_kick,
    input  logic              unavail_clr,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              fetch_req,
    output logic [1:0]        run_state,
    output logic              buf_unavail
);
    logic             advance;
    logic             unowned_hit;
    logic [IDX_W-1:0] pos_idx;

    txdma_run_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_en      (run_en),
        .desc_ack    (desc_ack),
        .desc_owned  (desc_owned),
        .frame_done  (frame_done),
        .poll_kick   (poll_kick),
        .advance     (advance),
        .unowned_hit (unowned_hit),
        .fetch_req   (fetch_req),
        .run_state   (run_state)
    );

    txdma_ring_pos #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W),
        .STRIDE (STRIDE)
    ) u_pos (
        .clk        (clk),
        .rst_n      (rst_n),
        .advance    (advance),
        .ring_base  (ring_base),
        .ring_count (ring_count),
        .idx        (pos_idx),
        .addr       (desc_addr)
    );

    txdma_sticky_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (unowned_hit),
        .clr   (unavail_clr),
        .q     (buf_unavail)
    );

endmodule

// File: rtl/txdma_run_chk.sv
// Property checker for txdma_run_ctrl, attached by bind.
// Assumes: ring_base and ring_count are held constant after reset.
module txdma_run_chk #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_en,
    input logic [IDX_W-1:0]  ring_count,
    input logic              desc_ack,
    input logic              desc_owned,
    input logic              frame_done,
    input logic              unavail_clr,
    input logic [ADDR_W-1:0] desc_addr,
    input logic              fetch_req,
    input logic [1:0]        run_state,
    input logic              buf_unavail,
    input logic [IDX_W-1:0]  pos_idx
);
    logic in_frame;
    logic bad_desc;
    assign in_frame = (run_state == 2'b01) && !fetch_req;
    assign bad_desc = fetch_req && run_en && desc_ack && !desc_owned;

    // R2: a start from stopped requests the descriptor next cycle.
    p_start_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b00 && run_en) |=> (run_state == 2'b01 && fetch_req));

    // R3: an unowned descriptor suspends and raises the flag.
    p_unowned_susp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bad_desc |=> (run_state == 2'b10 && buf_unavail));

    // R4: a frame in progress is never cut short.
    p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && !frame_done) |=> (run_state == 2'b01));

    // R4: a stop while suspended is immediate.
    p_susp_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b10 && !run_en) |=> (run_state == 2'b00));

    // R5: a finished frame moves to a new entry on rings longer than one.
    p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_frame && frame_done && ring_count > 1) |=> (desc_addr != $past(desc_addr)));

    // R6: the ring position is held while stopped.
    p_keep_pos_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b00) |=> $stable(pos_idx));

    // R8: the flag persists without a clear.
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_unavail && !unavail_clr) |=> buf_unavail);

    // R8: a clear without a new unowned descriptor drops the flag.
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (unavail_clr && !bad_desc) |=> !buf_unavail);

    // R9: no fetch is requested while stopped.
    p_quiet_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == 2'b00) |-> !fetch_req);

endmodule

bind txdma_run_ctrl txdma_run_chk #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_en      (run_en),
    .ring_count  (ring_count),
    .desc_ack    (desc_ack),
    .desc_owned  (desc_owned),
    .frame_done  (frame_done),
    .unavail_clr (unavail_clr),
    .desc_addr   (desc_addr),
    .fetch_req   (fetch_req),
    .run_state   (run_state),
    .buf_unavail (buf_unavail),
    .pos_idx     (pos_idx)
);

// File: tb/tb_txdma_run_ctrl.sv
// Bench for txdma_run_ctrl: a behavioural reference model advanced on
// each rising edge and compared with the outputs on each falling edge,
// plus directed checks tagged by requirement.
module tb_txdma_run_ctrl;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 8;
    localparam int STRIDE = 16;
    localparam logic [ADDR_W-1:0] BASE = 32'h4000_0100;
    localparam int COUNT = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_en = 0, desc_ack = 0, desc_owned = 0;
    logic              frame_done = 0, poll_kick = 0, unavail_clr = 0;
    logic [ADDR_W-1:0] ring_base = BASE;
    logic [IDX_W-1:0]  ring_count = IDX_W'(COUNT);
    logic [ADDR_W-1:0] desc_addr;
    logic              fetch_req;
    logic [1:0]        run_state;
    logic              buf_unavail;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    // Model: 0 stop, 1 fetch, 2 suspended, 3 frame in progress.
    int m_ph = 0;
    int m_idx = 0;
    bit m_flag = 0;

    always #4 clk = ~clk;

    txdma_run_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .STRIDE(STRIDE)) dut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .ring_base(ring_base),
        .ring_count(ring_count), .desc_ack(desc_ack), .desc_owned(desc_owned),
        .frame_done(frame_done), .poll_kick(poll_kick), .unavail_clr(unavail_clr),
        .desc_addr(desc_addr), .fetch_req(fetch_req), .run_state(run_state),
        .buf_unavail(buf_unavail)
    );

    // Reference model step.
    always @(posedge clk) begin
        bit set_f;
        set_f = 0;
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_flag = 0;
        end else begin
            case (m_ph)
                0: if (run_en) m_ph = 1;
                1: if (!run_en) m_ph = 0;
                   else if (desc_ack) begin
                       if (desc_owned) m_ph = 3;
                       else begin m_ph = 2; set_f = 1; end
                   end
                3: if (frame_done) begin
                       m_idx = (m_idx + 1) % COUNT;
                       m_ph = run_en ? 1 : 0;
                   end
                default: if (!run_en) m_ph = 0; else if (poll_kick) m_ph = 1;
            endcase
            if (set_f) m_flag = 1;
            else if (unavail_clr) m_flag = 0;
        end
    end

    function automatic logic [1:0] m_rs();
        return (m_ph == 1 || m_ph == 3) ? 2'b01 : (m_ph == 2) ? 2'b10 : 2'b00;
    endfunction

    task automatic chk(string req, string what, longint got, longint exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) if (rst_n) begin
        chk(cur_req, "state", run_state, m_rs());
        chk(cur_req, "fetch", fetch_req, m_ph == 1);
        chk(cur_req, "addr", desc_addr, BASE + m_idx * STRIDE);
        chk(cur_req, "flag", buf_unavail, m_flag);
    end

    // Drive one cycle of inputs from a falling edge to the next.
    task automatic cyc(bit run, bit ack = 0, bit own = 0, bit done = 0,
                       bit poll = 0, bit clr = 0);
        run_en = run; desc_ack = ack; desc_owned = own;
        frame_done = done; poll_kick = poll; unavail_clr = clr;
        @(negedge clk);
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk("R1", "reset state", run_state, 2'b00);
        chk("R1", "reset fetch", fetch_req, 0);
        chk("R1", "reset flag", buf_unavail, 0);
        chk("R1", "reset addr", desc_addr, BASE);

        cur_req = "R9";
        cyc(0, 1, 1, 1);
        chk("R9", "ack/done ignored when stopped", {run_state, desc_addr}, {2'b00, BASE});

        cur_req = "R7";
        cyc(0, 0, 0, 0, 1);
        chk("R7", "poll ignored when stopped", run_state, 2'b00);

        cur_req = "R2";
        cyc(1);
        chk("R2", "start running", run_state, 2'b01);
        chk("R2", "start fetch", fetch_req, 1);
        chk("R2", "first addr is base", desc_addr, BASE);

        cur_req = "R3";
        cyc(1);
        cyc(1, 1, 1);
        chk("R3", "owned ends fetch", fetch_req, 0);
        chk("R3", "owned stays running", run_state, 2'b01);
        cyc(1, 1, 0);
        chk("R9", "ack ignored mid frame", fetch_req, 0);

        cur_req = "R5";
        for (int k = 1; k <= COUNT; k++) begin
            cyc(1, 0, 0, 1);
            chk("R5", "advance addr", desc_addr, BASE + (k % COUNT) * STRIDE);
            chk("R5", "fetch next", fetch_req, 1);
            cyc(1, 1, 1);
        end
        chk("R5", "wrapped to base", desc_addr, BASE);

        cur_req = "R4";
        cyc(0);
        cyc(0);
        chk("R4", "stop deferred during frame", run_state, 2'b01);
        cyc(0, 0, 0, 1);
        chk("R4", "stop at frame end", run_state, 2'b00);

        cur_req = "R6";
        chk("R6", "saved position", desc_addr, BASE + 1 * STRIDE);
        cyc(0); cyc(0);
        cyc(1);
        chk("R6", "restart fetches saved", desc_addr, BASE + 1 * STRIDE);
        chk("R6", "restart requests", fetch_req, 1);

        cur_req = "R3";
        cyc(1, 1, 0);
        chk("R3", "unowned suspends", run_state, 2'b10);
        chk("R3", "unowned sets flag", buf_unavail, 1);

        cur_req = "R8";
        cyc(1); cyc(1);
        chk("R8", "flag sticky", buf_unavail, 1);

        cur_req = "R7";
        cyc(1, 0, 0, 0, 1);
        chk("R7", "poll refetches", fetch_req, 1);
        chk("R7", "same descriptor", desc_addr, BASE + 1 * STRIDE);
        cyc(1, 1, 0, 0, 0, 1);
        chk("R8", "set wins over clear", buf_unavail, 1);
        cyc(1, 0, 0, 0, 0, 1);
        chk("R8", "clear drops flag", buf_unavail, 0);
        cyc(1, 0, 0, 0, 1);
        cyc(1, 1, 1);
        chk("R7", "owned after poll runs", {run_state, fetch_req}, {2'b01, 1'b0});
        cyc(1, 0, 0, 0, 1);
        chk("R7", "poll ignored mid frame", fetch_req, 0);

        cur_req = "R4";
        cyc(1, 0, 0, 1);
        cyc(0);
        chk("R4", "stop during fetch immediate", run_state, 2'b00);
        cyc(1);
        cyc(1, 1, 0);
        chk("R4", "suspended again", run_state, 2'b10);
        cyc(0);
        chk("R4", "stop from suspended immediate", run_state, 2'b00);
        chk("R6", "position kept", desc_addr, BASE + 2 * STRIDE);

        cyc(0); cyc(0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule